// File: doc/BRIEF.md
# Processor Mode and Privilege Tracker

This block holds the execution context of a small processor core. It records whether the core is running ordinary code (thread mode) or servicing an exception (handler mode). It also records whether thread code runs privileged or unprivileged. It reports the number of the exception being serviced, and it gates accesses to protected system-control registers.

The core's sequencer drives the inputs:
- a one-cycle strobe on exception entry, carrying the exception number;
- a one-cycle strobe on exception return;
- a write port for the single privilege-control bit.

The load/store path raises a flag when an access targets protected system registers. The block grants that access in the same cycle, or it withholds the access and pulses a fault request on the next cycle.

Only one level of exception is tracked. An entry strobe that arrives while an exception is already being serviced is dropped.

Top module: `pm_priv_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block is in thread mode (`handler_mode`=0) and privileged (`priv_eff`=1). In that state `ipsr_num`=0, `sysreg_fault`=0, and the control bit reads as 0.
- R2: An entry strobe with a nonzero number, taken in thread mode, switches the block to handler mode on the next cycle. From then on `ipsr_num` shows that number.
- R3: An entry strobe is ignored, with mode and `ipsr_num` left unchanged, in either of these cases:
  - it carries number 0;
  - it arrives while the block is already in handler mode.
- R4: In handler mode `priv_eff` is 1 whatever value the control bit holds.
- R5: A control write made while privileged in thread mode loads the bit. A 1 makes thread code unprivileged from the next cycle. A 0 keeps it privileged.
- R6: A control write made while unprivileged in thread mode is ignored. This holds even when the write shares its cycle with an exception entry, so privilege cannot be regained without first entering handler mode.
- R7: A return strobe in handler mode has three effects on the next cycle:
  - the mode goes back to thread;
  - `ipsr_num` goes to 0;
  - `priv_eff` equals the inverse of the control bit.
  A return strobe in thread mode is ignored.
- R8: A control write of 0 made in handler mode makes thread code privileged after the return. When the write and the return fall in the same cycle, the newly written value applies.
- R9: A protected access has two outcomes:
  - while privileged, `sysreg_acc_grant` is 1 in the same cycle and no fault follows;
  - while unprivileged, the grant is 0 and `sysreg_fault` is 1 for exactly the following cycle, once per blocked access.
- R10: In thread mode, an entry strobe and a return strobe in the same cycle act as an entry. The return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_entry_vld | input | 1 | Exception entry strobe |
| exc_entry_num | input | EXC_W | Number of the exception being entered |
| exc_return_vld | input | 1 | Exception return strobe |
| ctrl_wr_en | input | 1 | Write strobe for the privilege-control bit |
| ctrl_wr_npriv | input | 1 | Value written; 1 requests unprivileged thread code |
| sysreg_acc_vld | input | 1 | Access to protected system registers this cycle |
| handler_mode | output | 1 | 1 in handler mode, 0 in thread mode |
| priv_eff | output | 1 | Effective privilege of the current code |
| ipsr_num | output | EXC_W | Active exception number, 0 in thread mode |
| sysreg_acc_grant | output | 1 | Protected access may complete |
| sysreg_fault | output | 1 | Fault request, one cycle after a blocked access |

## Verification
A control write can land in the same cycle as an exception entry or an exception return. In both cases the decision must use the privilege held before the clock edge.

The bench drives each coincidence directly:
- An unprivileged write of 0 together with an entry must be dropped. This is judged by the privilege seen after the later return.
- A handler write of 0 together with a return must take effect. This is judged by `priv_eff` in the first thread cycle.

A blocked access is also paired with an ignored control write. The bench confirms that the fault pulse appears and that privilege does not change.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } pm_mode_e;

    typedef struct packed {
        logic entry;
        logic ret;
        logic ctrl_wr;
        logic ctrl_val;
    } pm_evt_t;

    function automatic logic entry_accepted(input pm_mode_e mode, input logic entry,
                                            input logic num_nonzero);
        return entry && num_nonzero && (mode == MODE_THREAD);
    endfunction

    function automatic logic return_accepted(input pm_mode_e mode, input logic ret);
        return ret && (mode == MODE_HANDLER);
    endfunction

endpackage

// File: rtl/pm_mode_seq.sv
module pm_mode_seq
    import pm_pkg::*;
#(
    parameter int unsigned EXC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  pm_evt_t          evt,
    input  logic [EXC_W-1:0] num,
    output pm_mode_e         mode,
    output logic [EXC_W-1:0] ipsr
);
    localparam logic [EXC_W-1:0] NUM_NONE = '0;

    logic take_entry;
    logic take_ret;

    always_comb begin
        take_entry = entry_accepted(mode, evt.entry, num != NUM_NONE);
        take_ret   = return_accepted(mode, evt.ret);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_THREAD;
            ipsr <= NUM_NONE;
        end else if (take_entry) begin
            mode <= MODE_HANDLER;
            ipsr <= num;
        end else if (take_ret) begin
            mode <= MODE_THREAD;
            ipsr <= NUM_NONE;
        end
    end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    priv_now,
    input  pm_evt_t evt,
    output logic    npriv
);
    // Writes are accepted only from privileged code, judged before the edge.
    always_ff @(posedge clk) begin
        if (rst)
            npriv <= 1'b0;
        else if (evt.ctrl_wr && priv_now)
            npriv <= evt.ctrl_val;
    end
endmodule

// File: rtl/pm_access_gate.sv
module pm_access_gate
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pm_mode_e mode,
    input  logic     npriv,
    input  logic     acc_vld,
    output logic     priv_now,
    output logic     grant,
    output logic     fault
);
    always_comb begin
        priv_now = (mode == MODE_HANDLER) || !npriv;
        grant    = acc_vld && priv_now;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault <= 1'b0;
        else
            fault <= acc_vld && !priv_now;
    end
endmodule

// File: rtl/pm_priv_tracker.sv
module pm_priv_tracker
    import pm_pkg::*;
#(
    parameter int unsigned EXC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_entry_vld,
    input  logic [EXC_W-1:0] exc_entry_num,
    input  logic             exc_return_vld,
    input  logic             ctrl_wr_en,
    input  logic             ctrl_wr_npriv,
    input  logic             sysreg_acc_vld,
    output logic             handler_mode,
    output logic             priv_eff,
    output logic [EXC_W-1:0] ipsr_num,
    output logic             sysreg_acc_grant,
    output logic             sysreg_fault
);
    pm_evt_t  evt;
    pm_mode_e mode;
    logic     npriv;
    logic     priv_now;

    always_comb begin
        evt.entry    = exc_entry_vld;
        evt.ret      = exc_return_vld;
        evt.ctrl_wr  = ctrl_wr_en;
        evt.ctrl_val = ctrl_wr_npriv;
    end

    pm_mode_seq #(.EXC_W(EXC_W)) mode_i (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .num  (exc_entry_num),
        .mode (mode),
        .ipsr (ipsr_num)
    );

    pm_ctrl_reg ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .priv_now (priv_now),
        .evt      (evt),
        .npriv    (npriv)
    );

    pm_access_gate gate_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .npriv    (npriv),
        .acc_vld  (sysreg_acc_vld),
        .priv_now (priv_now),
        .grant    (sysreg_acc_grant),
        .fault    (sysreg_fault)
    );

    always_comb begin
        handler_mode = (mode == MODE_HANDLER);
        priv_eff     = priv_now;
    end
endmodule

// File: rtl/pm_priv_tracker_chk.sv
module pm_priv_tracker_chk #(
    parameter int unsigned EXC_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_entry_vld,
    input logic [EXC_W-1:0] exc_entry_num,
    input logic             exc_return_vld,
    input logic             ctrl_wr_en,
    input logic             sysreg_acc_vld,
    input logic             handler_mode,
    input logic             priv_eff,
    input logic [EXC_W-1:0] ipsr_num,
    input logic             sysreg_acc_grant,
    input logic             sysreg_fault
);
    a_r2_entry_loads: assert property (@(posedge clk) disable iff (rst)
        (!handler_mode && exc_entry_vld && exc_entry_num != '0)
        |=> (handler_mode && ipsr_num == $past(exc_entry_num)));

    a_r3_ipsr_matches_mode: assert property (@(posedge clk) disable iff (rst)
        handler_mode == (ipsr_num != '0));

    a_r3_nested_dropped: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && !exc_return_vld) |=> (handler_mode && $stable(ipsr_num)));

    a_r4_handler_privileged: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> priv_eff);

    a_r6_no_regain: assert property (@(posedge clk) disable iff (rst)
        (!handler_mode && !priv_eff && !exc_entry_vld) |=> !priv_eff);

    a_r7_return_clears: assert property (@(posedge clk) disable iff (rst)
        (handler_mode && exc_return_vld) |=> (!handler_mode && ipsr_num == '0));

    a_r9_blocked_faults: assert property (@(posedge clk) disable iff (rst)
        (sysreg_acc_vld && !priv_eff) |=> sysreg_fault);

    a_r9_no_spurious_fault: assert property (@(posedge clk) disable iff (rst)
        !(sysreg_acc_vld && !priv_eff) |=> !sysreg_fault);

    a_r9_grant_needs_priv: assert property (@(posedge clk) disable iff (rst)
        sysreg_acc_grant |-> (sysreg_acc_vld && priv_eff));

    logic unused_ok;
    assign unused_ok = ctrl_wr_en;
endmodule

bind pm_priv_tracker pm_priv_tracker_chk #(.EXC_W(EXC_W)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .exc_entry_vld    (exc_entry_vld),
    .exc_entry_num    (exc_entry_num),
    .exc_return_vld   (exc_return_vld),
    .ctrl_wr_en       (ctrl_wr_en),
    .sysreg_acc_vld   (sysreg_acc_vld),
    .handler_mode     (handler_mode),
    .priv_eff         (priv_eff),
    .ipsr_num         (ipsr_num),
    .sysreg_acc_grant (sysreg_acc_grant),
    .sysreg_fault     (sysreg_fault)
);

// File: tb/pm_priv_tracker_tb_top.sv
module pm_priv_tracker_tb_top;
    localparam int unsigned EXC_W = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             exc_entry_vld = 1'b0;
    logic [EXC_W-1:0] exc_entry_num = '0;
    logic             exc_return_vld = 1'b0;
    logic             ctrl_wr_en = 1'b0;
    logic             ctrl_wr_npriv = 1'b0;
    logic             sysreg_acc_vld = 1'b0;
    logic             handler_mode;
    logic             priv_eff;
    logic [EXC_W-1:0] ipsr_num;
    logic             sysreg_acc_grant;
    logic             sysreg_fault;

    always #5 clk = ~clk;

    pm_priv_tracker #(.EXC_W(EXC_W)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .exc_entry_vld    (exc_entry_vld),
        .exc_entry_num    (exc_entry_num),
        .exc_return_vld   (exc_return_vld),
        .ctrl_wr_en       (ctrl_wr_en),
        .ctrl_wr_npriv    (ctrl_wr_npriv),
        .sysreg_acc_vld   (sysreg_acc_vld),
        .handler_mode     (handler_mode),
        .priv_eff         (priv_eff),
        .ipsr_num         (ipsr_num),
        .sysreg_acc_grant (sysreg_acc_grant),
        .sysreg_fault     (sysreg_fault)
    );

    typedef struct packed {
        logic             hnd;
        logic             prv;
        logic [EXC_W-1:0] ipsr;
        logic             flt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    task automatic check_now(input string tag, input exp_t e);
        checks++;
        if (handler_mode !== e.hnd || priv_eff !== e.prv ||
            ipsr_num !== e.ipsr || sysreg_fault !== e.flt) begin
            failures++;
            $display("FAIL %s: got hnd=%0b prv=%0b ipsr=%0d flt=%0b exp hnd=%0b prv=%0b ipsr=%0d flt=%0b",
                     tag, handler_mode, priv_eff, ipsr_num, sysreg_fault,
                     e.hnd, e.prv, e.ipsr, e.flt);
        end
    endtask

    // Monitor: after each rising edge, compare against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0)
            check_now(tag_q.pop_front(), exp_q.pop_front());
    end

    // Driver: applies one cycle of stimulus at the falling edge, checks the
    // same-cycle grant, and queues the state expected after the next edge.
    task automatic step(input string tag, input logic ent, input int num,
                        input logic ret, input logic wr, input logic wv,
                        input logic acc, input logic exp_grant,
                        input logic e_hnd, input logic e_prv, input int e_ipsr,
                        input logic e_flt);
        exp_t e;
        @(negedge clk);
        exc_entry_vld  = ent;
        exc_entry_num  = EXC_W'(num);
        exc_return_vld = ret;
        ctrl_wr_en     = wr;
        ctrl_wr_npriv  = wv;
        sysreg_acc_vld = acc;
        #1;
        if (acc) begin
            checks++;
            if (sysreg_acc_grant !== exp_grant) begin
                failures++;
                $display("FAIL %s grant: got %0b exp %0b", tag, sysreg_acc_grant, exp_grant);
            end
        end
        e.hnd  = e_hnd;
        e.prv  = e_prv;
        e.ipsr = EXC_W'(e_ipsr);
        e.flt  = e_flt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        exc_entry_vld  = 1'b0;
        exc_return_vld = 1'b0;
        ctrl_wr_en     = 1'b0;
        sysreg_acc_vld = 1'b0;
    endtask

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r = '{hnd: 1'b0, prv: 1'b1, ipsr: '0, flt: 1'b0};
        check_now("R1 during reset", r);
        rst = 1'b0;
        @(negedge clk);
        check_now("R1 after reset", r);

        //     tag                          ent num ret wr wv acc gnt  hnd prv ipsr flt
        step("R9 privileged access",        0, 0,  0, 0, 0, 1, 1,   0, 1, 0,   0);
        step("R5 write 0 stays priv",       0, 0,  0, 1, 0, 0, 0,   0, 1, 0,   0);
        step("R7 return in thread ignored", 0, 0,  1, 0, 0, 0, 0,   0, 1, 0,   0);
        step("R3 entry number 0 ignored",   1, 0,  0, 0, 0, 0, 0,   0, 1, 0,   0);
        step("R5 write 1 drops priv",       0, 0,  0, 1, 1, 0, 0,   0, 0, 0,   0);
        step("R9 blocked access faults",    0, 0,  0, 0, 0, 1, 0,   0, 0, 0,   1);
        step("R9 fault is one pulse",       0, 0,  0, 0, 0, 0, 0,   0, 0, 0,   0);
        step("R6 unpriv write ignored",     0, 0,  0, 1, 0, 0, 0,   0, 0, 0,   0);
        step("R6 R9 write plus access",     0, 0,  0, 1, 0, 1, 0,   0, 0, 0,   1);
        step("R9 second pulse ends",        0, 0,  0, 0, 0, 0, 0,   0, 0, 0,   0);
        step("R10 R2 entry with return",    1, 19, 1, 0, 0, 0, 0,   1, 1, 19,  0);
        step("R3 nested entry dropped",     1, 5,  0, 0, 0, 0, 0,   1, 1, 19,  0);
        step("R4 handler access granted",   0, 0,  0, 0, 0, 1, 1,   1, 1, 19,  0);
        step("R7 return keeps unpriv",      0, 0,  1, 0, 0, 0, 0,   0, 0, 0,   0);
        step("R2 entry max number",         1, 511,0, 0, 0, 0, 0,   1, 1, 511, 0);
        step("R4 R8 handler clears bit",    0, 0,  0, 1, 0, 0, 0,   1, 1, 511, 0);
        step("R8 return privileged",        0, 0,  1, 0, 0, 0, 0,   0, 1, 0,   0);
        step("R5 drop priv again",          0, 0,  0, 1, 1, 0, 0,   0, 0, 0,   0);
        step("R2 entry number 3",           1, 3,  0, 0, 0, 0, 0,   1, 1, 3,   0);
        step("R4 handler sets bit",         0, 0,  0, 1, 1, 0, 0,   1, 1, 3,   0);
        step("R8 write 0 with return",      0, 0,  1, 1, 0, 0, 0,   0, 1, 0,   0);
        step("R5 drop priv third time",     0, 0,  0, 1, 1, 0, 0,   0, 0, 0,   0);
        step("R6 write with entry dropped", 1, 7,  0, 1, 0, 0, 0,   1, 1, 7,   0);
        step("R6 return still unpriv",      0, 0,  1, 0, 0, 0, 0,   0, 0, 0,   0);
        step("R2 entry before reset",       1, 42, 0, 0, 0, 0, 0,   1, 1, 42,  0);
        idle_inputs();
        repeat (3) @(negedge clk);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now("R1 reset from handler", r);

        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule